// File: doc/BRIEF.md
# Lane Receive Link Initialization Controller

This block runs the start-up sequence for one receive lane of an 8b/10b coded converter link. Each clock it takes one decoded octet with flags for control character, valid, decode error and disparity error. It holds an active-low synchronization request to the transmitter until it has seen an unbroken run of comma characters. It then waits for the control character that opens the alignment sequence.

The alignment sequence is four multiframes long. Each multiframe is `F*K` octets. The block pulses a marker at the start of each alignment multiframe and checks the octet that closes it. From the second multiframe it copies the configuration octets into a register vector. After the fourth multiframe it raises lane-ready and passes user octets through with a valid flag. A sticky error flag records framing violations. A run of line errors drops the lane back to synchronization.

Top module: `lane_rx_init`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `sync_req_n` is 0, and `lane_ready`, `mf_start`, `link_err`, `user_valid` and `cfg_data` are all 0.
- R2: An octet takes part in any rule only when `rx_valid` is 1. A cycle with `rx_valid` low is ignored: it neither advances nor breaks any count, and no state changes.
- R3: A comma is a control octet 0xBC taken with both error flags low. Four consecutive commas drive `sync_req_n` high on the next cycle. Any other octet that arrives before the run is complete restarts the count, and so does an octet with an error flag.
- R4: Once `sync_req_n` is high, a control octet 0x1C starts the alignment sequence. `mf_start` pulses for one cycle after the first octet of each of the four alignment multiframes, with `F*K` accepted octets per multiframe.
- R5: In the second alignment multiframe, the octet at position p (2 ≤ p ≤ F*K-2, with position 0 the start octet) is stored in `cfg_data[8*(p-2)+7 : 8*(p-2)]` on the cycle after it arrives.
- R6: Two conditions set `link_err`. The first is that the last octet of an alignment multiframe is not the control octet 0x7C. The second is that position 1 of the second multiframe is not the control octet 0x9C. `link_err` stays set until reset.
- R7: After the last octet of the fourth multiframe, `lane_ready` goes to 1. From then on, each accepted error-free octet shows up on `user_octet` one cycle later, with `user_valid` high for that single cycle.
- R8: During user data, a control octet that is neither 0x7C nor 0xFC sets `link_err`.
- R9: Four consecutive valid octets that carry a decode or disparity error return the block to synchronization. On the next cycle `sync_req_n` goes to 0 and `lane_ready` goes to 0. A clean octet inside the run resets the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_octet | input | 8 | Decoded octet |
| rx_is_ctrl | input | 1 | Octet is a control character |
| rx_valid | input | 1 | Octet present this cycle |
| rx_code_err | input | 1 | Decoder reported an invalid code |
| rx_disp_err | input | 1 | Running disparity error |
| sync_req_n | output | 1 | Synchronization request, low while requesting |
| mf_start | output | 1 | One-cycle pulse per alignment multiframe start |
| lane_ready | output | 1 | Alignment complete, user data phase |
| link_err | output | 1 | Sticky framing error |
| user_octet | output | 8 | User data octet |
| user_valid | output | 1 | `user_octet` holds a new octet |
| cfg_data | output | 8*(F*K-3) | Captured configuration octets |

## Verification
The embedded assertions hold on every cycle for the following:
- `lane_ready` implies a released synchronization request.
- User data appears only when the lane is ready.
- `mf_start` never lasts two cycles.
- The error flag never clears on its own.
- An idle (invalid) cycle leaves the request and the configuration unchanged and produces no user octet.
- The fourth consecutive line error drops the request.

Some behaviours need the bench's scenarios, which drive the lane through whole start-ups and compare against a behavioural model every clock. These are the exact comma-run counting with interruptions, the position of each configuration octet, the detection of a missing closing marker or a missing configuration marker, the illegal control characters in user data, and the recovery after a resynchronization.

// File: rtl/lane_rx_init.sv
module lane_rx_init #(
  parameter int F = 2,
  parameter int K = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             rx_octet,
  input  logic                   rx_is_ctrl,
  input  logic                   rx_valid,
  input  logic                   rx_code_err,
  input  logic                   rx_disp_err,
  output logic                   sync_req_n,
  output logic                   mf_start,
  output logic                   lane_ready,
  output logic                   link_err,
  output logic [7:0]             user_octet,
  output logic                   user_valid,
  output logic [8*(F*K-3)-1:0]   cfg_data
);
  localparam int MF    = F * K;
  localparam int CFG_N = MF - 3;
  localparam int PW    = (MF > 1) ? $clog2(MF) : 1;

  localparam logic [1:0] ST_HUNT = 2'd0, ST_CGS = 2'd1, ST_ILAS = 2'd2, ST_DATA = 2'd3;

  logic [1:0]    st;
  logic [1:0]    comma_cnt, bad_cnt, mf_idx;
  logic [PW-1:0] pos;

  wire good     = rx_valid & ~rx_code_err & ~rx_disp_err;
  wire bad      = rx_valid & (rx_code_err | rx_disp_err);
  wire is_k     = rx_is_ctrl && rx_octet == 8'hBC;
  wire is_start = rx_is_ctrl && rx_octet == 8'h1C;
  wire is_end   = rx_is_ctrl && rx_octet == 8'h7C;
  wire is_cfgk  = rx_is_ctrl && rx_octet == 8'h9C;
  wire is_fc    = rx_is_ctrl && rx_octet == 8'hFC;
  wire last_pos = pos == PW'(MF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_HUNT; comma_cnt <= '0; bad_cnt <= '0; mf_idx <= '0; pos <= '0;
      sync_req_n <= 1'b0; mf_start <= 1'b0; lane_ready <= 1'b0; link_err <= 1'b0;
      user_octet <= '0; user_valid <= 1'b0; cfg_data <= '0;
    end else begin
      mf_start   <= 1'b0;
      user_valid <= 1'b0;
      if (bad) begin
        comma_cnt <= '0;
        if (bad_cnt == 2'd3) begin
          st <= ST_HUNT; sync_req_n <= 1'b0; lane_ready <= 1'b0; bad_cnt <= '0;
        end else begin
          bad_cnt <= bad_cnt + 2'd1;
        end
      end else if (good) begin
        bad_cnt <= '0;
        case (st)
          ST_HUNT: begin
            if (!is_k) comma_cnt <= '0;
            else if (comma_cnt == 2'd3) begin
              st <= ST_CGS; sync_req_n <= 1'b1; comma_cnt <= '0;
            end else comma_cnt <= comma_cnt + 2'd1;
          end
          ST_CGS: begin
            if (is_start) begin
              st <= ST_ILAS; pos <= PW'(1); mf_idx <= '0; mf_start <= 1'b1;
            end
          end
          ST_ILAS: begin
            if (pos == '0) mf_start <= 1'b1;
            if (mf_idx == 2'd1 && pos == PW'(1) && !is_cfgk) link_err <= 1'b1;
            if (mf_idx == 2'd1)
              for (int i = 0; i < CFG_N; i++)
                if (pos == PW'(i + 2)) cfg_data[i*8 +: 8] <= rx_octet;
            if (last_pos) begin
              if (!is_end) link_err <= 1'b1;
              pos    <= '0;
              mf_idx <= mf_idx + 2'd1;
              if (mf_idx == 2'd3) begin
                st <= ST_DATA; lane_ready <= 1'b1;
              end
            end else begin
              pos <= pos + PW'(1);
            end
          end
          default: begin
            user_valid <= 1'b1;
            user_octet <= rx_octet;
            if (rx_is_ctrl && !is_end && !is_fc) link_err <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_READY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) lane_ready |-> sync_req_n); // R7
  AST_DATA_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n) user_valid |-> lane_ready); // R7
  AST_MF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mf_start |=> !mf_start); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) link_err |=> link_err); // R6
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(sync_req_n) && $stable(cfg_data) && !user_valid); // R2
  AST_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && bad_cnt == 2'd3) |=> !sync_req_n && !lane_ready); // R9
endmodule

// File: tb/lane_rx_init_bench.sv
module lane_rx_init_bench;
  localparam int F = 2, K = 8, MF = F * K, CW = 8 * (MF - 3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_octet = '0;
  logic rx_is_ctrl = 0, rx_valid = 0, rx_code_err = 0, rx_disp_err = 0;
  logic sync_req_n, mf_start, lane_ready, link_err, user_valid;
  logic [7:0] user_octet;
  logic [CW-1:0] cfg_data;
  int checks = 0, bad = 0, mf_pulses = 0;

  always #5 clk = ~clk;

  lane_rx_init #(.F(F), .K(K)) u_lane_rx_init (
    .clk, .rst_n, .rx_octet, .rx_is_ctrl, .rx_valid, .rx_code_err, .rx_disp_err,
    .sync_req_n, .mf_start, .lane_ready, .link_err, .user_octet, .user_valid, .cfg_data);

  // behavioural reference
  int m_phase, m_commas, m_errs, m_count;
  logic m_sync, m_rdy, m_mfs, m_err, m_uv;
  logic [7:0] m_uo;
  logic [CW-1:0] m_cfg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_commas = 0; m_errs = 0; m_count = 0;
      m_sync = 0; m_rdy = 0; m_mfs = 0; m_err = 0; m_uv = 0; m_uo = 0; m_cfg = '0;
    end else begin
      m_mfs = 0; m_uv = 0;
      if (rx_valid && (rx_code_err || rx_disp_err)) begin
        m_commas = 0; m_errs++;
        if (m_errs == 4) begin m_phase = 0; m_sync = 0; m_rdy = 0; m_errs = 0; end
      end else if (rx_valid) begin
        m_errs = 0;
        if (m_phase == 0) begin
          m_commas = (rx_is_ctrl && rx_octet == 8'hBC) ? m_commas + 1 : 0;
          if (m_commas == 4) begin m_phase = 1; m_sync = 1; m_commas = 0; end
        end else if (m_phase == 1) begin
          if (rx_is_ctrl && rx_octet == 8'h1C) begin m_phase = 2; m_count = 1; m_mfs = 1; end
        end else if (m_phase == 2) begin
          int p, mf;
          p = m_count % MF; mf = m_count / MF;
          if (p == 0) m_mfs = 1;
          if (mf == 1 && p == 1 && !(rx_is_ctrl && rx_octet == 8'h9C)) m_err = 1;
          if (mf == 1 && p >= 2 && p <= MF - 2) m_cfg[8*(p-2) +: 8] = rx_octet;
          if (p == MF - 1 && !(rx_is_ctrl && rx_octet == 8'h7C)) m_err = 1;
          m_count++;
          if (m_count == 4 * MF) begin m_phase = 3; m_rdy = 1; end
        end else begin
          m_uv = 1; m_uo = rx_octet;
          if (rx_is_ctrl && rx_octet != 8'h7C && rx_octet != 8'hFC) m_err = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time); end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(sync_req_n == m_sync, "R3/R9 sync_req_n", sync_req_n, m_sync);
    chk(lane_ready == m_rdy, "R7 lane_ready", lane_ready, m_rdy);
    chk(mf_start == m_mfs, "R4 mf_start", mf_start, m_mfs);
    chk(link_err == m_err, "R6/R8 link_err", link_err, m_err);
    chk(user_valid == m_uv, "R7 user_valid", user_valid, m_uv);
    if (m_uv) chk(user_octet == m_uo, "R7 user_octet", user_octet, m_uo);
    chk(cfg_data == m_cfg, "R5 cfg_data", cfg_data[63:0], m_cfg[63:0]);
    if (mf_start) mf_pulses++;
  end

  task automatic go(input logic [7:0] o, input bit c, input bit v = 1, input bit de = 0, input bit dp = 0);
    rx_octet = o; rx_is_ctrl = c; rx_valid = v; rx_code_err = de; rx_disp_err = dp;
    @(negedge clk);
  endtask

  task automatic commas(input int n);
    for (int i = 0; i < n; i++) go(8'hBC, 1);
  endtask

  task automatic ilas(input int bad_end_mf, input bit bad_cfgk);
    for (int mf = 0; mf < 4; mf++)
      for (int p = 0; p < MF; p++) begin
        if (p == 0) go(8'h1C, 1);
        else if (mf == 1 && p == 1) go(bad_cfgk ? 8'h55 : 8'h9C, !bad_cfgk);
        else if (p == MF - 1) go(mf == bad_end_mf ? 8'h33 : 8'h7C, mf != bad_end_mf);
        else go(mf == 1 ? 8'h40 + 8'(p) : 8'h10 + 8'(p), 0);
      end
  endtask

  task automatic do_reset;
    rst_n = 0; go(8'h00, 0, 0); go(8'h00, 0, 0); rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset;
    chk(sync_req_n == 0 && lane_ready == 0 && link_err == 0 && cfg_data == '0 && !user_valid,
        "R1 reset state", {sync_req_n, lane_ready, link_err}, 0);
    commas(2); go(8'h11, 0); commas(2); go(8'hBC, 1, 1, 0, 1); commas(2);
    chk(sync_req_n == 0, "R3 broken runs keep request", sync_req_n, 0);
    go(8'hBC, 1, 0); go(8'h00, 0, 0); commas(1);
    chk(sync_req_n == 0, "R2 idle cycles ignored", sync_req_n, 0);
    commas(1);
    chk(sync_req_n == 1, "R3 released after four commas", sync_req_n, 1);
    commas(3); go(8'h22, 0);
    mf_pulses = 0;
    ilas(-1, 0);
    chk(mf_pulses == 4, "R4 four multiframe pulses", mf_pulses, 4);
    chk(cfg_data[7:0] == 8'h42, "R5 first config octet", cfg_data[7:0], 8'h42);
    chk(cfg_data[CW-8 +: 8] == 8'h40 + 8'(MF - 2), "R5 last config octet", cfg_data[CW-8 +: 8], 8'h40 + MF - 2);
    chk(lane_ready == 1 && link_err == 0, "R7 ready without error", {lane_ready, link_err}, 2);
    go(8'hA5, 0);
    chk(user_valid && user_octet == 8'hA5, "R7 passthrough", user_octet, 8'hA5);
    go(8'h7C, 1); go(8'hFC, 1); go(8'h5A, 0, 0);
    for (int i = 0; i < 10; i++) go(8'(i * 7), 0);
    chk(link_err == 0, "R8 legal control octets", link_err, 0);
    go(8'hBC, 1);
    chk(link_err == 1, "R8 illegal control octet", link_err, 1);

    do_reset;
    commas(4); ilas(2, 0);
    chk(link_err == 1, "R6 missing end marker", link_err, 1);
    go(8'h01, 0, 1, 1); go(8'h02, 0, 1, 0, 1); go(8'h03, 0, 1, 1); go(8'h04, 0);
    chk(sync_req_n == 1 && lane_ready == 1, "R9 three errors tolerated", {sync_req_n, lane_ready}, 3);
    for (int i = 0; i < 3; i++) go(8'h05, 0, 1, 1);
    go(8'h00, 0, 0);
    go(8'h05, 0, 1, 0, 1);
    chk(sync_req_n == 0 && lane_ready == 0, "R9 resync after four errors", {sync_req_n, lane_ready}, 0);
    commas(4); ilas(-1, 0); go(8'h99, 0);
    chk(lane_ready == 1 && link_err == 1, "R6 error stays after relink", {lane_ready, link_err}, 3);

    do_reset;
    commas(4); ilas(-1, 1);
    chk(link_err == 1, "R6 missing config marker", link_err, 1);
    go(8'h00, 0, 0); go(8'h00, 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule